// File: doc/BRIEF.md
# Byte-Coded Four-Register Execution Core

This block is a small execution core. It consumes a stream of one-byte instructions and applies each one to a bank of four 8-bit general registers. Every instruction byte has three fields: an operation code, a destination register and a source register. The core computes additions, subtractions, exclusive-ORs, register copies and compares. It keeps a single zero flag that shows whether the last arithmetic or logic result was all zeros.

Two encodings would be useless if they were taken literally, because both name the same register twice. The core gives these encodings new meanings. A subtract of a register from itself inverts that register bit by bit. A copy of a register onto itself becomes a two-byte load: the byte that follows in the stream is written into the register as a literal value. While the core waits for that literal byte, it does not treat the byte as an instruction.

The stream arrives over a valid/ready handshake. Each operation that writes a register or the flag takes one extra writeback cycle, and the core holds ready low during that cycle. The register contents and the flag are always visible on outputs, so surrounding logic or a bench can observe the architectural state directly.

Top module: `byte_reg_core`

## Requirements
- R1: After a synchronous active-high reset, all four registers read zero, the zero flag is 0, `ins_ready` is 1, and the next accepted byte is decoded as an instruction.
- R2: An instruction byte is decoded as follows. Bits [7:4] are the operation code, bits [3:2] select the destination register Rx, and bits [1:0] select the source register Ry. Opcode 0xA is ADD and sets Rx to (Rx + Ry) modulo 256. No register other than Rx changes.
- R3: Opcode 0xB with Rx different from Ry sets Rx to (Rx - Ry) modulo 256.
- R4: Opcode 0xC sets Rx to Rx XOR Ry.
- R5: Opcode 0xB with Rx equal to Ry sets Rx to its bitwise complement. This result is not forced to zero.
- R6: Opcode 0xD with Rx different from Ry copies Ry into Rx and leaves the zero flag unchanged.
- R7: Opcode 0xD with Rx equal to Ry writes the next accepted byte into Rx unchanged. That byte is never decoded as an instruction, whatever its value, and the zero flag is unchanged. `ins_ready` stays 1 between the two bytes.
- R8: Opcode 0xE sets the zero flag to 1 when (Rx - Ry) modulo 256 is zero and to 0 otherwise. It writes no register.
- R9: ADD, SUB, XOR and the complement form set the zero flag to 1 exactly when their 8-bit result is zero.
- R10: Opcodes 0x0 to 0x9 and 0xF change no register and do not change the zero flag. `ins_ready` stays 1 after they are accepted.
- R11: A byte is accepted on a rising edge where both `ins_valid` and `ins_ready` are 1. When the accepted byte is a writing operation or a literal byte, `ins_ready` is 0 for the next cycle only. The result appears after the following edge. A byte presented while `ins_ready` is 0 is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction or literal byte is offered |
| ins_byte | input | 8 | Instruction or literal byte |
| ins_ready | output | 1 | The core can take a byte this cycle |
| reg_view | output | 32 | Register contents, R0 in [7:0] up to R3 in [31:24] |
| zero_flag | output | 1 | Zero result of the last ADD, SUB, XOR, NOT or CMP |

## Verification
A byte that is accepted on edge k moves into a pending slot. Its register or flag result lands on edge k+1. A first literal-load byte or a no-operation byte lands nothing. The bench therefore samples `ins_ready` at the falling edge just after acceptance and expects it to be low exactly for the writing cases. It then samples the register view and the flag one falling edge later, once the writeback edge has passed. The sweep covers all 256 instruction bytes, each preceded by register preloads, and a reference model in the bench computes the expected state arithmetically. Directed cases cover a byte held while ready is low, an ADD that wraps to zero, and a literal byte that looks like an opcode.

// File: rtl/byte_core_pkg.sv
package byte_core_pkg;

    localparam int WORD_W = 8;
    localparam int OPC_W  = 4;
    localparam int SEL_W  = 2;
    localparam int NREG   = 1 << SEL_W;
    localparam int INS_W  = OPC_W + 2 * SEL_W;
    localparam int VIEW_W = NREG * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [OPC_W-1:0]  opc_t;
    typedef logic [INS_W-1:0]  ins_t;

    localparam opc_t OPC_ADD = 4'hA;
    localparam opc_t OPC_SUB = 4'hB;
    localparam opc_t OPC_XOR = 4'hC;
    localparam opc_t OPC_MOV = 4'hD;
    localparam opc_t OPC_CMP = 4'hE;

    typedef enum logic [2:0] {
        K_NOP, K_ADD, K_SUB, K_XOR, K_NOT, K_MOV, K_CMP, K_IMM
    } kind_e;

    typedef enum logic {
        ST_OPC,
        ST_IMM
    } seq_e;

    typedef struct packed {
        kind_e kind;
        sel_t  dst;
        sel_t  src;
        logic  busy;
    } dec_t;

    typedef struct packed {
        kind_e kind;
        sel_t  dst;
        sel_t  src;
        word_t imm;
    } pend_t;

    function automatic dec_t decode_byte(input ins_t b);
        dec_t d;
        opc_t op;
        op     = b[INS_W-1 -: OPC_W];
        d.dst  = b[2*SEL_W-1 -: SEL_W];
        d.src  = b[SEL_W-1:0];
        d.kind = K_NOP;
        unique case (op)
            OPC_ADD: d.kind = K_ADD;
            OPC_SUB: d.kind = (d.dst == d.src) ? K_NOT : K_SUB;
            OPC_XOR: d.kind = K_XOR;
            OPC_MOV: d.kind = (d.dst == d.src) ? K_IMM : K_MOV;
            OPC_CMP: d.kind = K_CMP;
            default: d.kind = K_NOP;
        endcase
        d.busy = (d.kind != K_NOP) && (d.kind != K_IMM);
        return d;
    endfunction

endpackage

// File: rtl/byte_decoder.sv
module byte_decoder
    import byte_core_pkg::*;
(
    input  ins_t ins,
    output dec_t dec
);

    always_comb begin
        dec = decode_byte(ins);
    end

    // R7
    always_comb begin
        if (dec.kind == K_IMM) begin
            imm_same_sel_chk: assert (ins[2*SEL_W-1 -: SEL_W] == ins[SEL_W-1:0]);
        end
    end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_core_pkg::*;
(
    input  kind_e kind,
    input  word_t opa,
    input  word_t opb,
    input  word_t imm,
    output word_t result,
    output logic  res_zero,
    output logic  wr_reg,
    output logic  wr_flag
);

    always_comb begin
        result  = '0;
        wr_reg  = 1'b0;
        wr_flag = 1'b0;
        unique case (kind)
            K_ADD: begin result = opa + opb; wr_reg = 1'b1; wr_flag = 1'b1; end
            K_SUB: begin result = opa - opb; wr_reg = 1'b1; wr_flag = 1'b1; end
            K_XOR: begin result = opa ^ opb; wr_reg = 1'b1; wr_flag = 1'b1; end
            K_NOT: begin result = ~opa;      wr_reg = 1'b1; wr_flag = 1'b1; end
            K_MOV: begin result = opb;       wr_reg = 1'b1; end
            K_CMP: begin result = opa - opb; wr_flag = 1'b1; end
            K_IMM: begin result = imm;       wr_reg = 1'b1; end
            default: begin result = '0; end
        endcase
        res_zero = (result == '0);
    end

    // R2
    always_comb begin
        if (kind == K_ADD) begin
            add_inverse_chk: assert (word_t'(result - opb) == opa);
        end
    end

    // R3
    always_comb begin
        if (kind == K_SUB) begin
            sub_inverse_chk: assert (word_t'(result + opb) == opa);
        end
    end

    // R8
    always_comb begin
        if (kind == K_CMP) begin
            cmp_equal_chk: assert (res_zero == (opa == opb));
        end
    end

endmodule

// File: rtl/byte_regfile.sv
module byte_regfile
    import byte_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  sel_t              waddr,
    input  word_t             wdata,
    input  sel_t              raddr_a,
    input  sel_t              raddr_b,
    output word_t             rdata_a,
    output word_t             rdata_b,
    output logic [VIEW_W-1:0] view
);

    word_t q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (we && waddr == sel_t'(i)) begin
                q[i] <= wdata;
            end
        end
        assign view[i*WORD_W +: WORD_W] = q[i];
    end

    assign rdata_a = q[raddr_a];
    assign rdata_b = q[raddr_b];

    word_t            q_prev [NREG];
    logic             prev_ok;
    logic [NREG-1:0]  chg;

    for (genvar i = 0; i < NREG; i++) begin : g_prev
        always_ff @(posedge clk) begin
            if (rst) q_prev[i] <= '0;
            else     q_prev[i] <= q[i];
        end
        assign chg[i] = (q[i] != q_prev[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) prev_ok <= 1'b0;
        else     prev_ok <= 1'b1;
    end

    // R2
    single_dest_chk: assert property (@(posedge clk) disable iff (rst)
        prev_ok |-> ($countones(chg) <= 1));

endmodule

// File: rtl/byte_reg_core.sv
module byte_reg_core
    import byte_core_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ins_valid,
    input  logic [INS_W-1:0]         ins_byte,
    output logic                     ins_ready,
    output logic [NREG*WORD_W-1:0]   reg_view,
    output logic                     zero_flag
);

    seq_e  state;
    sel_t  imm_dst;
    pend_t pend;
    logic  pend_v;
    logic  zf;
    logic  acc;
    dec_t  dec;

    word_t rd_a;
    word_t rd_b;
    word_t alu_res;
    logic  alu_zero;
    logic  alu_wr_reg;
    logic  alu_wr_flag;

    assign ins_ready = !pend_v;
    assign acc       = ins_valid && ins_ready;
    assign zero_flag = zf;

    byte_decoder u_dec (
        .ins (ins_byte),
        .dec (dec)
    );

    byte_alu u_alu (
        .kind     (pend.kind),
        .opa      (rd_a),
        .opb      (rd_b),
        .imm      (pend.imm),
        .result   (alu_res),
        .res_zero (alu_zero),
        .wr_reg   (alu_wr_reg),
        .wr_flag  (alu_wr_flag)
    );

    byte_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (pend_v && alu_wr_reg),
        .waddr   (pend.dst),
        .wdata   (alu_res),
        .raddr_a (pend.dst),
        .raddr_b (pend.src),
        .rdata_a (rd_a),
        .rdata_b (rd_b),
        .view    (reg_view)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OPC;
            imm_dst <= '0;
            pend    <= '0;
            pend_v  <= 1'b0;
            zf      <= 1'b0;
        end else begin
            pend_v <= 1'b0;
            if (pend_v && alu_wr_flag) begin
                zf <= alu_zero;
            end
            if (acc) begin
                if (state == ST_IMM) begin
                    pend.kind <= K_IMM;
                    pend.dst  <= imm_dst;
                    pend.src  <= imm_dst;
                    pend.imm  <= ins_byte;
                    pend_v    <= 1'b1;
                    state     <= ST_OPC;
                end else if (dec.kind == K_IMM) begin
                    imm_dst <= dec.dst;
                    state   <= ST_IMM;
                end else if (dec.busy) begin
                    pend.kind <= dec.kind;
                    pend.dst  <= dec.dst;
                    pend.src  <= dec.src;
                    pend.imm  <= '0;
                    pend_v    <= 1'b1;
                end
            end
        end
    end

    // R11
    wb_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && state == ST_OPC && dec.busy) |=> !ins_ready);

    // R11
    stall_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        !ins_ready |=> ins_ready);

    // R7
    imm_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && state == ST_OPC && dec.kind == K_IMM) |=> (state == ST_IMM && ins_ready));

    // R10
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && state == ST_OPC && dec.kind == K_NOP)
        |=> (ins_ready && $stable(zero_flag) && $stable(reg_view)));

endmodule

// File: tb/byte_reg_core_bench.sv
module byte_reg_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [7:0]  ins_byte = '0;
    logic        ins_ready;
    logic [31:0] reg_view;
    logic        zero_flag;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mr [4];
    logic       mz;

    always #4 clk = ~clk;

    byte_reg_core u_byte_reg_core (
        .clk       (clk),
        .rst       (rst),
        .ins_valid (ins_valid),
        .ins_byte  (ins_byte),
        .ins_ready (ins_ready),
        .reg_view  (reg_view),
        .zero_flag (zero_flag)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        logic [31:0] exp;
        exp = {mr[3], mr[2], mr[1], mr[0]};
        checks++;
        if (reg_view !== exp || zero_flag !== mz) begin
            fails++;
            $display("FAIL %s: actual regs %h z %0b expected regs %h z %0b",
                     tag, reg_view, zero_flag, exp, mz);
        end
    endtask

    // drives at a falling edge, returns at the falling edge after acceptance
    task automatic send(input logic [7:0] b);
        ins_byte  = b;
        ins_valid = 1'b1;
        while (!ins_ready) @(negedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic load_reg(input int r, input logic [7:0] v);
        send({4'hD, r[1:0], r[1:0]});
        send(v);
        mr[r] = v;
    endtask

    task automatic settle();
        while (!ins_ready) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mr[i] = '0;
        mz = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_state("R1 reset");
        check_bit("R1 ready after reset", ins_ready, 1'b1);

        // R9 ADD wrapping to zero
        load_reg(0, 8'hC8);
        load_reg(1, 8'h38);
        settle();
        send(8'hA1);
        mr[0] = 8'h00; mz = 1'b1;
        check_bit("R11 ready low after ADD", ins_ready, 1'b0);
        @(negedge clk);
        check_state("R9 ADD wrap to zero");

        // R11 byte held while ready low consumed once
        load_reg(0, 8'h3C);
        load_reg(1, 8'hF0);
        settle();
        ins_byte = 8'hC1; ins_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ins_byte = 8'h00; ins_valid = 1'b0;
        mr[0] = 8'h3C ^ 8'hF0; mz = 1'b0;
        check_state("R11 held byte applied once");

        // R7 literal that looks like an immediate opcode, then a NOP
        settle();
        load_reg(2, 8'hDA);
        settle();
        send(8'h00);
        check_bit("R7 back to opcode state", ins_ready, 1'b1);
        @(negedge clk);
        check_state("R7 literal not decoded");

        // near-exhaustive sweep over every instruction byte
        for (int b = 0; b < 256; b++) begin
            logic [3:0] op;
            logic [1:0] x, y;
            logic [7:0] res;
            logic       wr;
            string      tag;
            op = b[7:4]; x = b[3:2]; y = b[1:0];
            settle();
            for (int i = 0; i < 4; i++) begin
                if (b % 3 == 0) load_reg(i, 8'(b * 29 + 5));
                else            load_reg(i, 8'(b * 29 + i * 71 + 5));
            end
            settle();
            wr = 1'b1;
            case (op)
                4'hA: begin res = mr[x] + mr[y]; mr[x] = res; mz = (res == 0); tag = "R2 ADD"; end
                4'hB: begin
                    if (x == y) begin res = ~mr[x]; tag = "R5 NOT"; end
                    else        begin res = mr[x] - mr[y]; tag = "R3 SUB"; end
                    mr[x] = res; mz = (res == 0);
                end
                4'hC: begin res = mr[x] ^ mr[y]; mr[x] = res; mz = (res == 0); tag = "R4 XOR"; end
                4'hD: begin
                    if (x == y) begin mr[x] = 8'(b) ^ 8'h5A; tag = "R7 IMM"; end
                    else        begin mr[x] = mr[y]; tag = "R6 MOV"; end
                end
                4'hE: begin res = mr[x] - mr[y]; mz = (res == 0); tag = "R8 CMP"; end
                default: begin wr = 1'b0; tag = "R10 NOP"; end
            endcase
            send(8'(b));
            if (op == 4'hD && x == y) begin
                check_bit("R7 ready between bytes", ins_ready, 1'b1);
                send(8'(b) ^ 8'h5A);
            end
            check_bit({tag, " R11 ready"}, ins_ready, !wr);
            @(negedge clk);
            check_state(tag);
        end

        report();
        $finish;
    end

endmodule